// File: doc/BRIEF.md
# Latency-Balanced Four-Operand Stream Adder

This block sums four integer streams, one sample of each per clock, and returns one sum per clock. Each two-input adder is a pipeline with a fixed number of register stages. Every stage holds a different sample, so several results are in progress at once. The operands that join the computation later are sent through delay lines first. The lengths of these delay lines follow an as-soon-as-possible schedule: each adder's output time is the latest arrival time of its operands plus its own latency, and an operand that arrives early is held back by the difference. With this alignment, every adder combines samples that share a stream index.

A parameter chooses how the three adders are connected. In the chained form the result is ((a + b) + c) + d. This form needs operand delays of one and two adder latencies on the third and fourth streams. In the tree form the result is (a + b) + (c + d). This form needs no operand delay and has a shorter total latency. A valid bit travels alongside the data and marks which output cycles carry a result. There is no backpressure, so the block accepts a sample on every cycle in which the input-valid bit is high.

Top module: `stream_sum4`

## Requirements
- R1: When out_vld is high, out_sum equals in_a + in_b + in_c + in_d of one accepted sample, where an accepted sample is a cycle in which in_vld is high.
- R2: In the chained form (FORM = FORM_CHAIN), each result appears exactly 3*ADD_LAT cycles after its sample is accepted. This is 30 cycles with the defaults.
- R3: In the tree form (FORM = FORM_TREE), each result appears exactly 2*ADD_LAT cycles after its sample is accepted. This is 20 cycles with the defaults.
- R4: out_vld is in_vld delayed by the total latency. Idle gaps in the input appear in the output with the same positions and the same lengths.
- R5: Samples accepted on consecutive cycles give results on consecutive cycles, and each result is built from operands of a single sample. This alignment is what the operand delays of ADD_LAT on in_c and 2*ADD_LAT on in_d in the chained form provide.
- R6: While rst is high, and on the cycle after it is sampled high, out_vld is low. Samples accepted before a reset never produce a valid output.
- R7: Data presented while in_vld is low never produces a valid output.
- R8: Sums are taken modulo 2^W. For example, four operands of all ones give all ones except the two lowest bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the valid pipeline |
| in_vld | input | 1 | The four operands on this cycle form a sample |
| in_a | input | W | First operand stream |
| in_b | input | W | Second operand stream |
| in_c | input | W | Third operand stream |
| in_d | input | W | Fourth operand stream |
| out_vld | output | 1 | out_sum carries a result |
| out_sum | output | W | Four-operand sum, modulo 2^W |

## Verification
The bench gives every sample distinct values on all four operands and sends them back to back, so that an operand delay line of the wrong length shows up immediately. A design with a misaligned delay would add c or d from a neighbouring sample and produce a wrong sum. A design with an off-by-one total latency would deliver its results one cycle early or late against the scoreboard's due cycle. Both forms are run side by side. The bench also checks three further cases: gaps in the input must reappear in the output with their original shape, samples in flight when a reset arrives must disappear, and all-ones operands must wrap modulo 2^W.

// File: rtl/sum4_pkg.sv
package sum4_pkg;

    typedef enum logic {
        FORM_CHAIN = 1'b0,
        FORM_TREE  = 1'b1
    } form_e;

    // ASAP arrival delay that must be added to operand idx (0..3)
    function automatic int unsigned operand_delay(form_e form, int unsigned lat, int unsigned idx);
        if (form == FORM_TREE) return 0;
        if (idx < 2) return 0;
        return (idx - 1) * lat;
    endfunction

    // Total input-to-output latency of the schedule
    function automatic int unsigned sched_latency(form_e form, int unsigned lat);
        return (form == FORM_TREE) ? 2 * lat : 3 * lat;
    endfunction

endpackage

// File: rtl/delay_line.sv
module delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 10
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] taps [DEPTH];
            always_ff @(posedge clk) begin
                taps[0] <= din;
                for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
            end
            assign dout = taps[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/pipe_adder.sv
module pipe_adder #(
    parameter int W   = 16,
    parameter int LAT = 10
) (
    input  logic         clk,
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    output logic [W-1:0] sum
);
    generate
        if (LAT == 0) begin : g_comb
            assign sum = op_x + op_y;
        end else begin : g_pipe
            logic [W-1:0] stg [LAT];
            always_ff @(posedge clk) begin
                stg[0] <= op_x + op_y;
                for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
            end
            assign sum = stg[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/valid_pipe.sv
module valid_pipe #(
    parameter int DEPTH = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic vin,
    output logic vout
);
    localparam int CW = $clog2(DEPTH + 2) + 1;
    localparam logic [CW-1:0] SAT = CW'(DEPTH + 1);

    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= (sr << 1) | DEPTH'(vin);
    end
    assign vout = sr[DEPTH-1];

    // Checker state: cycles since reset and since the last accepted sample
    logic [CW-1:0] fill_cnt;
    logic [CW-1:0] since_vin;
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt  <= '0;
            since_vin <= SAT;
        end else begin
            if (fill_cnt != SAT) fill_cnt <= fill_cnt + 1'b1;
            if (vin)                 since_vin <= '0;
            else if (since_vin != SAT) since_vin <= since_vin + 1'b1;
        end
    end

    AST_RESET_FLUSH: assert property (@(posedge clk) rst |=> !vout); // R6
    AST_FILL_BEFORE_VALID: assert property (@(posedge clk) disable iff (rst)
        vout |-> fill_cnt >= CW'(DEPTH)); // R4
    AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        vout |-> since_vin < CW'(DEPTH)); // R7
endmodule

// File: rtl/stream_sum4.sv
module stream_sum4 #(
    parameter int              W       = 16,
    parameter int              ADD_LAT = 10,
    parameter sum4_pkg::form_e FORM    = sum4_pkg::FORM_CHAIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    input  logic [W-1:0] in_d,
    output logic         out_vld,
    output logic [W-1:0] out_sum
);
    import sum4_pkg::*;

    localparam int TOTAL = sched_latency(FORM, ADD_LAT);

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
        logic [W-1:0] d;
    } quad_t;

    quad_t        raw, aligned;
    logic [W-1:0] raw_op [4];
    logic [W-1:0] al_op  [4];

    assign raw      = '{a: in_a, b: in_b, c: in_c, d: in_d};
    assign raw_op[0] = raw.a;
    assign raw_op[1] = raw.b;
    assign raw_op[2] = raw.c;
    assign raw_op[3] = raw.d;

    // ASAP operand alignment: each operand waits for its adder's other input
    generate
        for (genvar k = 0; k < 4; k++) begin : g_align
            delay_line #(
                .W    (W),
                .DEPTH(int'(operand_delay(FORM, ADD_LAT, k)))
            ) u_dly (
                .clk (clk),
                .din (raw_op[k]),
                .dout(al_op[k])
            );
        end
    endgenerate

    assign aligned = '{a: al_op[0], b: al_op[1], c: al_op[2], d: al_op[3]};

    logic [W-1:0] sum_l, sum_r;

    pipe_adder #(.W(W), .LAT(ADD_LAT)) u_add_first (
        .clk(clk), .op_x(aligned.a), .op_y(aligned.b), .sum(sum_l)
    );

    generate
        if (FORM == FORM_CHAIN) begin : g_chain
            logic [W-1:0] sum_mid;
            pipe_adder #(.W(W), .LAT(ADD_LAT)) u_add_mid (
                .clk(clk), .op_x(sum_l), .op_y(aligned.c), .sum(sum_mid)
            );
            assign sum_r = aligned.d;
            pipe_adder #(.W(W), .LAT(ADD_LAT)) u_add_last (
                .clk(clk), .op_x(sum_mid), .op_y(sum_r), .sum(out_sum)
            );
        end else begin : g_tree
            pipe_adder #(.W(W), .LAT(ADD_LAT)) u_add_right (
                .clk(clk), .op_x(aligned.c), .op_y(aligned.d), .sum(sum_r)
            );
            pipe_adder #(.W(W), .LAT(ADD_LAT)) u_add_last (
                .clk(clk), .op_x(sum_l), .op_y(sum_r), .sum(out_sum)
            );
        end
    endgenerate

    valid_pipe #(.DEPTH(TOTAL)) u_vld (
        .clk (clk),
        .rst (rst),
        .vin (in_vld),
        .vout(out_vld)
    );

    AST_VALID_DATA_KNOWN: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> !$isunknown(out_sum)); // R1
endmodule

// File: tb/tb_stream_sum4.sv
module tb_stream_sum4;
    import sum4_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int LAT        = 10;
    localparam int LAT_CHAIN  = 3 * LAT;   // R2
    localparam int LAT_TREE   = 2 * LAT;   // R3

    typedef struct {
        logic [W-1:0] sum;
        int           due;
        int           req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
    logic         vld_chain, vld_tree;
    logic [W-1:0] sum_chain, sum_tree;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q_chain [$];
    exp_t q_tree  [$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stream_sum4 #(.W(W), .ADD_LAT(LAT), .FORM(FORM_CHAIN)) dut (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .out_vld(vld_chain), .out_sum(sum_chain)
    );

    stream_sum4 #(.W(W), .ADD_LAT(LAT), .FORM(FORM_TREE)) dut_tree (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .out_vld(vld_tree), .out_sum(sum_tree)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Driver: present one sample for one cycle and record expectations
    task automatic send(input logic [W-1:0] a, b, c, d, input int req);
        exp_t e;
        in_vld = 1'b1; in_a = a; in_b = b; in_c = c; in_d = d;
        e.sum = a + b + c + d;
        e.req = req;
        e.due = cyc + LAT_CHAIN; q_chain.push_back(e);
        e.due = cyc + LAT_TREE;  q_tree.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_vld = 1'b0;
            in_a = W'(16'hDEAD + i); in_b = W'(i); in_c = 16'h5555; in_d = 16'h7777;
            @(negedge clk);
        end
    endtask

    // Monitor: compare results against the scoreboard at the cycle they fall due
    task automatic monitor(input bit tree, input logic v, input logic [W-1:0] s);
        exp_t  e;
        string nm = tree ? "tree" : "chain";
        if (tree) begin
            while (q_tree.size() > 0 && q_tree[0].due < cyc) begin
                e = q_tree.pop_front();
                check(1'b0, $sformatf("R%0d %s missing result due %0d", e.req, nm, e.due), 0, int'(e.sum));
            end
        end else begin
            while (q_chain.size() > 0 && q_chain[0].due < cyc) begin
                e = q_chain.pop_front();
                check(1'b0, $sformatf("R%0d %s missing result due %0d", e.req, nm, e.due), 0, int'(e.sum));
            end
        end
        if (v) begin
            if (tree ? (q_tree.size() == 0) : (q_chain.size() == 0)) begin
                check(1'b0, $sformatf("R7 %s unexpected out_vld at cycle %0d", nm, cyc), 1, 0);
            end else begin
                e = tree ? q_tree.pop_front() : q_chain.pop_front();
                check(e.due == cyc,
                      $sformatf("R%0d %s latency (R%0d) cycle", e.req, nm, tree ? 3 : 2), cyc, e.due);
                check(s === e.sum, $sformatf("R%0d %s sum", e.req, nm), int'(s), int'(e.sum));
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            monitor(1'b0, vld_chain, sum_chain);
            monitor(1'b1, vld_tree,  sum_tree);
        end
    end

    task automatic check_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            check(!vld_chain && !vld_tree, $sformatf("%s out_vld low", tag),
                  int'({vld_chain, vld_tree}), 0);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        check(!vld_chain && !vld_tree, "R6 out_vld during reset", int'({vld_chain, vld_tree}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R5: back-to-back samples, every operand distinct per index
        for (int i = 0; i < 12; i++)
            send(W'(16'h0100 + i), W'(16'h0200 + 3*i), W'(16'h1000 + 17*i), W'(16'h4000 + 101*i), 5);
        // R4: gap pattern with single holes and a longer hole
        idle(1);
        send(16'h0011, 16'h0022, 16'h0033, 16'h0044, 4);
        idle(2);
        send(16'h0101, 16'h0202, 16'h0303, 16'h0404, 4);
        send(16'h1111, 16'h2222, 16'h3333, 16'h4444, 4);
        idle(5);
        send(16'h000F, 16'h00F0, 16'h0F00, 16'hF000, 1);
        // R8: wrap modulo 2^W
        send(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8);
        send(16'h8000, 16'h8000, 16'h0001, 16'h0002, 8);
        // R7: data while in_vld low; then drain everything
        idle(LAT_CHAIN + 5);
        check(q_chain.size() == 0 && q_tree.size() == 0, "R1 scoreboard drained",
              q_chain.size() + q_tree.size(), 0);
        check_quiet(10, "R7 idle data ignored");

        // R6: reset flushes samples in flight
        for (int i = 0; i < 4; i++) send(W'(i + 1), W'(i + 2), W'(i + 3), W'(i + 4), 6);
        idle(3);
        rst = 1'b1;
        q_chain.delete();
        q_tree.delete();
        @(negedge clk);
        check(!vld_chain && !vld_tree, "R6 out_vld after reset edge", int'({vld_chain, vld_tree}), 0);
        @(negedge clk);
        rst = 1'b0;
        check_quiet(LAT_CHAIN + 5, "R6 flushed samples");

        // R5: pipeline works again after reset
        for (int i = 0; i < 6; i++)
            send(W'(16'h3000 - i), W'(16'h0700 + i), W'(16'h0050 * i), W'(16'h9000 + i), 5);
        idle(LAT_CHAIN + 3);
        check(q_chain.size() == 0 && q_tree.size() == 0, "R5 scoreboard drained after reset",
              q_chain.size() + q_tree.size(), 0);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end
endmodule